// File: doc/BRIEF.md
# Read-Sequence Triggered Nonvolatile Memory Controller

This block is a synchronous model of a byte-wide static memory that carries a shadow nonvolatile copy of itself. On the outside it looks like a plain SRAM: an address, a write data bus, a read data bus and three active-low controls (chip enable, output enable, write enable), all sampled once on each cycle in which the access strobe is high. The byte count is `2**ADDR_W`; with `ADDR_W = 13` it holds 8192 bytes.

Saving the working array into the shadow copy (STORE) and bringing the shadow copy back (RECALL) are requested without any extra pins. The host reads six fixed addresses in a row. Five lead-in addresses are followed by a final address that picks the operation. Any write, or any read that breaks the order, cancels the request. STORE first clears the shadow copy and then copies every byte into it. RECALL copies the shadow copy back. While either one runs, `busy` is high and every access is dropped. A low-supply input blocks a STORE from starting and cuts short a STORE that is already running.

Top module: `nvs_ctrl`

## Requirements
- R1: A strobed access with ce_n=0, oe_n=0 and we_n=1 loads the byte at addr into rdata, visible after the next rising edge. Any strobed cycle that is not such a read leaves rdata unchanged.
- R2: A strobed access with ce_n=0 and we_n=0 stores wdata at addr. A later read of addr returns it.
- R3: With ce_n=1 a strobed cycle writes nothing, leaves rdata unchanged and neither advances nor cancels a pending trigger sequence.
- R4: Reading, in order, the low ADDR_W bits of 0x0000, 0x1555, 0x0AAA, 0x1FFF and 0x10F0, then 0x0F0F, starts a STORE. busy is high from the edge that samples the sixth read for exactly STORE_CYC cycles.
- R5: The same five lead-in reads followed by 0x0F0E (low ADDR_W bits) start a RECALL. busy is high for exactly RECALL_CYC cycles.
- R6: A completed STORE followed by a RECALL restores every byte to its value at the time of the STORE, even if the array was overwritten in between.
- R7: A write, or a read whose address is not the next expected one, cancels the sequence. Completing the remaining steps afterwards starts nothing.
- R8: oe_n does not take part in sequence matching. A read with ce_n=0 and we_n=1 counts as a sequence step whatever oe_n is.
- R9: A read that breaks the order but is itself the first lead-in address restarts the sequence at its second step.
- R10: While busy is high, writes are dropped, rdata holds and sequence reads have no effect.
- R11: A STORE is not started when low_supply is high on the sixth read. busy stays low.
- R12: If low_supply is high while a STORE runs, busy falls one cycle later. The copy phase has not run, so a later RECALL returns the older shadow contents for bytes beyond the erase point.
- R13: Reset clears rdata and busy, returns the sequence to its start and fills the shadow copy with zeros. A RECALL right after reset yields zero bytes.
- R14: Reads used as sequence steps with oe_n=0 still return array data on rdata.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_stb | input | 1 | Access strobe; the controls are sampled when high |
| ce_n | input | 1 | Active-low chip enable |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| addr | input | ADDR_W | Byte address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| low_supply | input | 1 | Supply-low indication |
| busy | output | 1 | High while STORE or RECALL runs |

## Verification
The bench builds the block with ADDR_W = 8, which gives a 256-byte array, and sets STORE_CYC = 540 and RECALL_CYC = 270. Each operation then finishes in a few hundred cycles. This lets the bench measure the busy window to the exact cycle and still run several full STORE/RECALL round trips. The eight-bit width keeps all seven key addresses distinct, so cancellation, restart at the first key and the choice between the two final keys are all tested on the real decoding. Because the erase phase runs in index order, an early supply-low abort leaves the top address untouched, and the bench can see this through a RECALL.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

   // Phases of the nonvolatile engine
   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_ERASE = 3'd1,
      PH_PROG  = 3'd2,
      PH_SHOLD = 3'd3,
      PH_RCOPY = 3'd4,
      PH_RHOLD = 3'd5
   } nvs_phase_e;

   // Number of lead-in keys that precede the selecting key
   localparam int KEY_PREFIX = 5;
   localparam int STEP_W     = $clog2(KEY_PREFIX + 1);

   // Final keys choosing the operation (truncated to the address width)
   localparam logic [15:0] KEY_STORE  = 16'h0F0F;
   localparam logic [15:0] KEY_RECALL = 16'h0F0E;

   // Lead-in key for a given step of the sequence
   function automatic logic [15:0] prefix_key(int step);
      case (step)
         0:       return 16'h0000;
         1:       return 16'h1555;
         2:       return 16'h0AAA;
         3:       return 16'h1FFF;
         default: return 16'h10F0;
      endcase
   endfunction

endpackage

// File: rtl/nvs_seq_detect.sv
module nvs_seq_detect
   import nvs_pkg::*;
#(
   parameter int ADDR_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              seq_rd,
   input  logic              wr_any,
   input  logic [ADDR_W-1:0] addr,
   input  logic              low_supply,
   output logic              go_store,
   output logic              go_recall,
   output logic [STEP_W-1:0] step
);

   logic [KEY_PREFIX-1:0] hit;
   logic                  hit_store;
   logic                  hit_recall;
   logic                  hit_next;
   logic [STEP_W-1:0]     step_q;
   logic [STEP_W-1:0]     step_d;

   // One comparator per lead-in key
   for (genvar g = 0; g < KEY_PREFIX; g++) begin : g_key
      localparam logic [15:0] KFULL = prefix_key(g);
      assign hit[g] = (addr == KFULL[ADDR_W-1:0]);
   end

   assign hit_store  = (addr == KEY_STORE[ADDR_W-1:0]);
   assign hit_recall = (addr == KEY_RECALL[ADDR_W-1:0]);

   // Match against the key expected at the current step
   always_comb begin
      hit_next = 1'b0;
      for (int i = 0; i < KEY_PREFIX; i++) begin
         if (step_q == STEP_W'(i)) hit_next = hit[i];
      end
   end

   always_comb begin
      step_d    = step_q;
      go_store  = 1'b0;
      go_recall = 1'b0;
      if (wr_any) begin
         step_d = '0;
      end else if (seq_rd) begin
         if (step_q == STEP_W'(KEY_PREFIX)) begin
            go_store  = hit_store && !low_supply;
            go_recall = hit_recall;
            if (hit_store || hit_recall) step_d = '0;
            else if (hit[0])             step_d = STEP_W'(1);
            else                         step_d = '0;
         end else if (hit_next) begin
            step_d = step_q + STEP_W'(1);
         end else if (hit[0]) begin
            step_d = STEP_W'(1);
         end else begin
            step_d = '0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) step_q <= '0;
      else        step_q <= step_d;
   end

   assign step = step_q;

endmodule

// File: rtl/nvs_sequencer.sv
module nvs_sequencer
   import nvs_pkg::*;
#(
   parameter int ADDR_W     = 10,
   parameter int STORE_CYC  = 2100,
   parameter int RECALL_CYC = 1040
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go_store,
   input  logic              go_recall,
   input  logic              low_supply,
   output logic              busy,
   output logic              store_act,
   output logic              erase_we,
   output logic              prog_we,
   output logic              rcl_we,
   output logic [ADDR_W-1:0] idx
);

   localparam int DEPTH   = 1 << ADDR_W;
   localparam int MAX_CYC = (STORE_CYC > RECALL_CYC) ? STORE_CYC : RECALL_CYC;
   localparam int TW      = $clog2(MAX_CYC + 1);

   nvs_phase_e    phase_q;
   logic [TW-1:0] tick_q;
   logic [TW-1:0] tick_nx;

   assign tick_nx = tick_q + TW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         tick_q  <= '0;
      end else begin
         case (phase_q)
            PH_IDLE: begin
               tick_q <= '0;
               if (go_store)       phase_q <= PH_ERASE;
               else if (go_recall) phase_q <= PH_RCOPY;
            end
            PH_ERASE, PH_PROG, PH_SHOLD: begin
               if (low_supply) begin
                  phase_q <= PH_IDLE;
               end else if (tick_q == TW'(STORE_CYC - 1)) begin
                  phase_q <= PH_IDLE;
               end else begin
                  tick_q <= tick_nx;
                  if (tick_nx == TW'(DEPTH))          phase_q <= PH_PROG;
                  else if (tick_nx == TW'(2 * DEPTH)) phase_q <= PH_SHOLD;
               end
            end
            PH_RCOPY, PH_RHOLD: begin
               if (tick_q == TW'(RECALL_CYC - 1)) begin
                  phase_q <= PH_IDLE;
               end else begin
                  tick_q <= tick_nx;
                  if (tick_nx == TW'(DEPTH)) phase_q <= PH_RHOLD;
               end
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   // Word index: lower bits of the tick (DEPTH is a power of two)
   assign idx       = tick_q[ADDR_W-1:0];
   assign busy      = (phase_q != PH_IDLE);
   assign store_act = (phase_q == PH_ERASE) || (phase_q == PH_PROG) ||
                      (phase_q == PH_SHOLD);
   assign erase_we  = (phase_q == PH_ERASE);
   assign prog_we   = (phase_q == PH_PROG);
   assign rcl_we    = (phase_q == PH_RCOPY);

endmodule

// File: rtl/nvs_array.sv
module nvs_array #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_rd,
   input  logic              acc_wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              erase_we,
   input  logic              prog_we,
   input  logic              rcl_we,
   input  logic [ADDR_W-1:0] idx,
   output logic [DATA_W-1:0] rdata
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] sram   [DEPTH];
   logic [DATA_W-1:0] shadow [DEPTH];

   // Working array: restore path has priority, host writes otherwise
   always_ff @(posedge clk) begin
      if (rcl_we)      sram[idx]  <= shadow[idx];
      else if (acc_wr) sram[addr] <= wdata;
   end

   // Shadow copy, cleared by a synchronous reset sweep
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) shadow[i] <= '0;
      end else if (erase_we) begin
         shadow[idx] <= '0;
      end else if (prog_we) begin
         shadow[idx] <= sram[idx];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rdata <= '0;
      else if (acc_rd) rdata <= sram[addr];
   end

endmodule

// File: rtl/nvs_ctrl.sv
module nvs_ctrl
   import nvs_pkg::*;
#(
   parameter int ADDR_W     = 10,
   parameter int DATA_W     = 8,
   parameter int STORE_CYC  = 2100,
   parameter int RECALL_CYC = 1040
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_stb,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              low_supply,
   output logic              busy
);

   localparam int DEPTH = 1 << ADDR_W;

   // Elaboration-time parameter checks
   if (ADDR_W < 8 || ADDR_W > 16) begin : g_bad_addr_w
      $error("nvs_ctrl: ADDR_W must lie in 8..16 so the keys stay distinct");
   end
   if (DATA_W < 1) begin : g_bad_data_w
      $error("nvs_ctrl: DATA_W must be positive");
   end
   if (STORE_CYC < 2 * DEPTH) begin : g_bad_store
      $error("nvs_ctrl: STORE_CYC must cover the erase and copy sweeps");
   end
   if (RECALL_CYC < DEPTH) begin : g_bad_recall
      $error("nvs_ctrl: RECALL_CYC must cover the restore sweep");
   end

   logic              seq_rd;
   logic              acc_rd;
   logic              acc_wr;
   logic              go_store;
   logic              go_recall;
   logic              store_act;
   logic              erase_we;
   logic              prog_we;
   logic              rcl_we;
   logic [ADDR_W-1:0] idx;
   logic [STEP_W-1:0] seq_step;

   // Access decode, all gated off while an operation runs
   assign seq_rd = acc_stb && !ce_n && we_n && !busy;
   assign acc_rd = seq_rd && !oe_n;
   assign acc_wr = acc_stb && !ce_n && !we_n && !busy;

   nvs_seq_detect #(.ADDR_W(ADDR_W)) u_det (
      .clk        (clk),
      .rst_n      (rst_n),
      .seq_rd     (seq_rd),
      .wr_any     (acc_wr),
      .addr       (addr),
      .low_supply (low_supply),
      .go_store   (go_store),
      .go_recall  (go_recall),
      .step       (seq_step)
   );

   nvs_sequencer #(
      .ADDR_W     (ADDR_W),
      .STORE_CYC  (STORE_CYC),
      .RECALL_CYC (RECALL_CYC)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .go_store   (go_store),
      .go_recall  (go_recall),
      .low_supply (low_supply),
      .busy       (busy),
      .store_act  (store_act),
      .erase_we   (erase_we),
      .prog_we    (prog_we),
      .rcl_we     (rcl_we),
      .idx        (idx)
   );

   nvs_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
      .clk      (clk),
      .rst_n    (rst_n),
      .acc_rd   (acc_rd),
      .acc_wr   (acc_wr),
      .addr     (addr),
      .wdata    (wdata),
      .erase_we (erase_we),
      .prog_we  (prog_we),
      .rcl_we   (rcl_we),
      .idx      (idx),
      .rdata    (rdata)
   );

endmodule

// File: rtl/nvs_ctrl_chk.sv
module nvs_ctrl_chk #(
   parameter int DATA_W = 8,
   parameter int STEP_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              acc_stb,
   input logic              ce_n,
   input logic              we_n,
   input logic              low_supply,
   input logic              busy,
   input logic              store_act,
   input logic [STEP_W-1:0] seq_step,
   input logic [DATA_W-1:0] rdata
);

   // R10: read data cannot move while an operation runs
   a_r10_rdata_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(rdata));

   // R10: the sequence detector is deaf while busy
   a_r10_step_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(seq_step));

   // R4 / R5: an operation only begins after a strobed sequence read
   a_r4_busy_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(acc_stb && !ce_n && we_n));

   // R11: a low supply keeps a STORE from beginning
   a_r11_no_start_low: assert property (@(posedge clk) disable iff (!rst_n)
      (!store_act && low_supply) |=> !store_act);

   // R12: a low supply ends a running STORE on the next edge
   a_r12_abort_store: assert property (@(posedge clk) disable iff (!rst_n)
      (store_act && low_supply) |=> !busy);

endmodule

bind nvs_ctrl nvs_ctrl_chk #(.DATA_W(DATA_W), .STEP_W(nvs_pkg::STEP_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .acc_stb    (acc_stb),
   .ce_n       (ce_n),
   .we_n       (we_n),
   .low_supply (low_supply),
   .busy       (busy),
   .store_act  (store_act),
   .seq_step   (seq_step),
   .rdata      (rdata)
);

// File: tb/sim_nvs_ctrl.sv
`timescale 1ns/1ps
module sim_nvs_ctrl;

   localparam int AW = 8;
   localparam int DW = 8;
   localparam int SC = 540;
   localparam int RC = 270;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          acc_stb = 1'b0;
   logic          ce_n = 1'b1;
   logic          oe_n = 1'b1;
   logic          we_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic          low_supply = 1'b0;
   logic [DW-1:0] rdata;
   logic          busy;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   nvs_ctrl #(.ADDR_W(AW), .DATA_W(DW), .STORE_CYC(SC), .RECALL_CYC(RC)) u0 (
      .clk(clk), .rst_n(rst_n), .acc_stb(acc_stb), .ce_n(ce_n), .oe_n(oe_n),
      .we_n(we_n), .addr(addr), .wdata(wdata), .rdata(rdata),
      .low_supply(low_supply), .busy(busy)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // Key addresses: 0..4 lead-in, 5 selects STORE, 6 selects RECALL
   function automatic logic [AW-1:0] key(input int i);
      logic [15:0] v;
      case (i)
         0: v = 16'h0000;
         1: v = 16'h1555;
         2: v = 16'h0AAA;
         3: v = 16'h1FFF;
         4: v = 16'h10F0;
         5: v = 16'h0F0F;
         default: v = 16'h0F0E;
      endcase
      return v[AW-1:0];
   endfunction

   task automatic acc(input logic c, input logic o, input logic w,
                      input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      acc_stb = 1'b1; ce_n = c; oe_n = o; we_n = w; addr = a; wdata = d;
      @(negedge clk);
      acc_stb = 1'b0; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      acc(1'b0, 1'b1, 1'b0, a, d);
   endtask

   task automatic rd(input logic [AW-1:0] a);
      acc(1'b0, 1'b0, 1'b1, a, '0);
   endtask

   task automatic lead_in(input logic o);
      for (int i = 0; i < 5; i++) acc(1'b0, o, 1'b1, key(i), '0);
   endtask

   task automatic count_busy(output int n);
      n = 0;
      while (busy === 1'b1 && n < 100000) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic t_reset();
      chk("R13 busy after reset", busy, 0);
      chk("R13 rdata after reset", rdata, 0);
   endtask

   task automatic t_rw();
      wr(8'h03, 8'hA5);
      wr(8'h80, 8'h3C);
      rd(8'h03);
      chk("R2 R1 read back 03", rdata, 8'hA5);
      rd(8'h80);
      chk("R2 R1 read back 80", rdata, 8'h3C);
      acc(1'b0, 1'b1, 1'b1, 8'h03, '0);
      chk("R1 oe high keeps rdata", rdata, 8'h3C);
      acc(1'b1, 1'b0, 1'b0, 8'h03, 8'h11);
      acc(1'b1, 1'b0, 1'b1, 8'h03, '0);
      chk("R3 deselected read keeps rdata", rdata, 8'h3C);
      rd(8'h03);
      chk("R3 deselected write dropped", rdata, 8'hA5);
   endtask

   task automatic t_recall_reset();
      int n;
      wr(8'h00, 8'h11);
      rd(key(0));
      chk("R14 sequence read data", rdata, 8'h11);
      lead_in(1'b0);
      acc(1'b0, 1'b0, 1'b1, key(6), '0);
      chk("R5 busy on recall", busy, 1);
      count_busy(n);
      chk("R5 recall length", n, RC);
      rd(8'h03);
      chk("R13 shadow zero after reset", rdata, 0);
   endtask

   task automatic t_store();
      int n;
      wr(8'h00, 8'h5A);
      wr(8'h03, 8'h77);
      wr(8'hFF, 8'hC3);
      lead_in(1'b1);
      acc(1'b0, 1'b1, 1'b1, key(5), '0);
      chk("R8 R4 busy on store with oe high", busy, 1);
      count_busy(n);
      chk("R4 store length", n, SC);
      wr(8'h03, 8'h00);
      wr(8'hFF, 8'h00);
      wr(8'h00, 8'h00);
      rd(8'h03);
      chk("R2 overwrite", rdata, 0);
      lead_in(1'b0);
      acc(1'b0, 1'b0, 1'b1, key(6), '0);
      count_busy(n);
      chk("R5 recall length 2", n, RC);
      rd(8'h03);
      chk("R6 restore 03", rdata, 8'h77);
      rd(8'hFF);
      chk("R6 restore FF", rdata, 8'hC3);
      rd(8'h00);
      chk("R6 restore 00", rdata, 8'h5A);
   endtask

   task automatic t_abort();
      int n;
      for (int i = 0; i < 3; i++) rd(key(i));
      wr(8'h40, 8'h01);
      rd(key(3)); rd(key(4)); rd(key(5));
      @(negedge clk);
      chk("R7 write cancels", busy, 0);
      for (int i = 0; i < 4; i++) rd(key(i));
      rd(8'h12);
      rd(key(4)); rd(key(5));
      @(negedge clk);
      chk("R7 stray read cancels", busy, 0);
      for (int i = 0; i < 3; i++) rd(key(i));
      acc(1'b1, 1'b0, 1'b0, 8'h40, 8'h02);
      acc(1'b1, 1'b0, 1'b1, 8'h12, '0);
      rd(key(3)); rd(key(4)); rd(key(6));
      chk("R3 deselected cycles keep sequence", busy, 1);
      count_busy(n);
      chk("R5 recall length 3", n, RC);
   endtask

   task automatic t_restart();
      int n;
      wr(key(1), 8'h6B);
      rd(key(0));
      rd(key(1));
      chk("R14 key1 data", rdata, 8'h6B);
      rd(key(0));
      for (int i = 1; i < 5; i++) rd(key(i));
      rd(key(6));
      chk("R9 restart at step two", busy, 1);
      count_busy(n);
      chk("R9 recall length", n, RC);
   endtask

   task automatic t_busy_ignore();
      int n;
      logic [DW-1:0] held;
      lead_in(1'b0);
      rd(key(5));
      chk("R4 busy on store", busy, 1);
      held = rdata;
      wr(8'h03, 8'hEE);
      rd(8'hFF);
      chk("R10 rdata held", rdata, held);
      lead_in(1'b0);
      rd(key(5));
      count_busy(n);
      repeat (3) @(negedge clk);
      chk("R10 sequence during busy ignored", busy, 0);
      rd(8'h03);
      chk("R10 write during busy dropped", rdata, 8'h77);
   endtask

   task automatic t_low_block();
      low_supply = 1'b1;
      lead_in(1'b0);
      rd(key(5));
      chk("R11 store blocked", busy, 0);
      @(negedge clk);
      chk("R11 store still blocked", busy, 0);
      low_supply = 1'b0;
   endtask

   task automatic t_low_abort();
      int n;
      wr(8'hFF, 8'h99);
      lead_in(1'b0);
      rd(key(5));
      chk("R12 store started", busy, 1);
      low_supply = 1'b1;
      @(negedge clk);
      chk("R12 busy falls on low supply", busy, 0);
      low_supply = 1'b0;
      lead_in(1'b0);
      rd(key(6));
      count_busy(n);
      rd(8'hFF);
      chk("R12 shadow kept older byte", rdata, 8'hC3);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_rw();
      t_recall_reset();
      t_store();
      t_abort();
      t_restart();
      t_busy_ignore();
      t_low_block();
      t_low_abort();
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #750000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule